// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block produces the timing for an audio serial port from one fast port clock that runs at either 512 or 384 times the sample rate. It issues two single-cycle clock enables. The first marks each period of the audio master clock. The second marks each sample frame, which is the base that the bit clock logic counts from. A single base bit picks one of the two ratio families. A 3-bit multiplier code then picks how many master clock periods fit in one frame. The port clock is divided by 1, 2, 4, 8 or 16 to do this.

The control inputs come from the register shared with the serial port and are registered once on entry. The output runs only while the run control is set, the gate control is clear, and the code is legal for the selected family. An illegal code raises an error flag and holds both enables low. While the block is running, a new ratio is applied only at the end of the current sample frame. That point is also a terminal count of the divider, so no master clock period is ever cut short or stretched.

Top module: `amclk_gen`

## Requirements
- R1: While rst_ni is low, and afterwards until run is first requested, mclk_en_o, fs_en_o, mclk_valid_o and code_err_o are all 0.
- R2: With base_sel_i = 0, a frame lasts 512 port clocks, and codes 0, 1, 2, 3 and 4 give 32, 64, 128, 256 and 512 mclk_en_o pulses per frame.
- R3: With base_sel_i = 1, a frame lasts 384 port clocks, and codes 0, 1, 2 and 3 give 48, 96, 192 and 384 mclk_en_o pulses per frame.
- R4: mclk_en_o pulses are evenly spaced, every frame_length / ratio port clocks (16, 8, 4, 2 or 1).
- R5: A code above 4 with base_sel_i = 0, or above 3 with base_sel_i = 1, sets code_err_o one clock edge after it is applied, and holds mclk_valid_o and both enables low.
- R6: Setting gate_i or clearing run_i stops all enables and clears mclk_valid_o, starting one clock edge after the change.
- R7: When run_i = 1, gate_i = 0 and the code is legal, mclk_valid_o rises on the second clock edge. The base and code present at that time set the first frame.
- R8: A base or code change while running leaves the current frame at the old ratio. The change applies from the next frame, and no pulse spacing other than the old or the new one appears.
- R9: Every fs_en_o pulse coincides with an mclk_en_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock (512 or 384 times the sample rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_sel_i | input | 1 | Ratio family: 0 = 512-fs, 1 = 384-fs |
| mult_code_i | input | 3 | Master clock multiplier code |
| run_i | input | 1 | Run control |
| gate_i | input | 1 | Clock gate control, 1 stops output |
| mclk_en_o | output | 1 | One pulse per master clock period |
| fs_en_o | output | 1 | One pulse per sample frame |
| mclk_valid_o | output | 1 | Master clock output is running |
| code_err_o | output | 1 | Multiplier code is illegal for the family |

## Verification
Every legal code of both families is started from the stopped state. For each one the bench counts master clock pulses per frame, the frame length, and the smallest and largest pulse spacing. Together these separate the two families, the five division factors, and a divider whose count is off by one. A ratio change made just after a frame boundary shows whether the change waits for the next frame. Gate, run and illegal codes in both families are each applied while running, which shows that each one can stop the output on its own.

// File: rtl/amclk_pkg.sv
package amclk_pkg;
  localparam int CODE_W = 3;
  localparam int SH_W   = 3;

  typedef struct packed {
    logic              base;
    logic [SH_W-1:0]   shift;
  } ratio_t;
endpackage

// File: rtl/amclk_ctl.sv
module amclk_ctl import amclk_pkg::*; #(
  parameter int TOP_A = 4,
  parameter int TOP_B = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_sel_i,
  input  logic [CODE_W-1:0] mult_code_i,
  input  logic              run_i,
  input  logic              gate_i,
  output ratio_t            ratio_o,
  output logic              on_o,
  output logic              err_o
);
  logic              base_q, run_q, gate_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] top_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= 1'b0;
      code_q <= '0;
      run_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      base_q <= base_sel_i;
      code_q <= mult_code_i;
      run_q  <= run_i;
      gate_q <= gate_i;
    end
  end

  assign top_code      = base_q ? CODE_W'(TOP_B) : CODE_W'(TOP_A);
  assign err_o         = code_q > top_code;
  assign ratio_o.base  = base_q;
  assign ratio_o.shift = SH_W'(top_code - code_q);
  assign on_o          = run_q & ~gate_q & ~err_o;

  p_err_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && (($past(base_sel_i) && $past(mult_code_i) > 3'd3) ||
                       (!$past(base_sel_i) && $past(mult_code_i) > 3'd4))) |-> err_o);
  p_err_stops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !on_o);
endmodule

// File: rtl/amclk_div.sv
module amclk_div import amclk_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            live_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            tc_o
);
  logic [CNT_W-1:0] cnt_q, lim;

  assign lim  = CNT_W'((32'd1 << shift_i) - 32'd1);
  assign tc_o = live_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!live_i || tc_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_i && $stable(shift_i) |-> cnt_q <= lim);
endmodule

// File: rtl/amclk_frame.sv
module amclk_frame #(
  parameter int FRAME_A = 512,
  parameter int FRAME_B = 384,
  localparam int FCNT_W = $clog2(FRAME_A)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  input  logic base_i,
  output logic tc_o
);
  logic [FCNT_W-1:0] cnt_q, lim;

  assign lim  = base_i ? FCNT_W'(FRAME_B - 1) : FCNT_W'(FRAME_A - 1);
  assign tc_o = live_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!live_i || tc_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/amclk_gen.sv
module amclk_gen import amclk_pkg::*; #(
  parameter int FRAME_A = 512,
  parameter int FRAME_B = 384,
  parameter int TOP_A   = 4,
  parameter int TOP_B   = 3,
  localparam int CNT_W  = TOP_A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_sel_i,
  input  logic [CODE_W-1:0] mult_code_i,
  input  logic              run_i,
  input  logic              gate_i,
  output logic              mclk_en_o,
  output logic              fs_en_o,
  output logic              mclk_valid_o,
  output logic              code_err_o
);
  ratio_t cfg, act_q;
  logic   on, live_q, run_now, div_tc, frame_tc;

  amclk_ctl #(.TOP_A(TOP_A), .TOP_B(TOP_B)) i_ctl (
    .clk_i, .rst_ni, .base_sel_i, .mult_code_i, .run_i, .gate_i,
    .ratio_o(cfg), .on_o(on), .err_o(code_err_o)
  );

  assign run_now = live_q & on;

  // new ratio is taken while idle or at a frame end (also a divider end)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      act_q  <= '0;
    end else begin
      live_q <= on;
      if (!run_now || frame_tc) act_q <= cfg;
    end
  end

  amclk_div #(.CNT_W(CNT_W)) i_div (
    .clk_i, .rst_ni, .live_i(run_now), .shift_i(act_q.shift), .tc_o(div_tc)
  );

  amclk_frame #(.FRAME_A(FRAME_A), .FRAME_B(FRAME_B)) i_frame (
    .clk_i, .rst_ni, .live_i(run_now), .base_i(act_q.base), .tc_o(frame_tc)
  );

  assign mclk_en_o    = div_tc;
  assign fs_en_o      = frame_tc;
  assign mclk_valid_o = run_now;

  p_gate_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(gate_i) |-> !mclk_valid_o && !mclk_en_o);
  p_run_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> !mclk_valid_o && !fs_en_o);
  p_hold_ratio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_valid_o && !fs_en_o |=> $stable(act_q));
  p_frame_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_en_o |-> mclk_en_o);
  p_err_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o |-> !mclk_valid_o);
endmodule

// File: tb/test_amclk_gen.sv
module test_amclk_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       base_sel_i = 1'b0;
  logic [2:0] mult_code_i = 3'd0;
  logic       run_i = 1'b0;
  logic       gate_i = 1'b0;
  logic       mclk_en_o, fs_en_o, mclk_valid_o, code_err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  amclk_gen i_amclk_gen (
    .clk_i, .rst_ni, .base_sel_i, .mult_code_i, .run_i, .gate_i,
    .mclk_en_o, .fs_en_o, .mclk_valid_o, .code_err_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input bit wait_fs, output int pulses, output int len,
                         output int gmin, output int gmax, output int misal);
    int last, guard, gap;
    pulses = 0; len = 0; gmin = 100000; gmax = 0; misal = 0; last = 0;
    if (wait_fs) begin
      guard = 0;
      do begin @(negedge clk_i); guard++; end while (!fs_en_o && guard < 3000);
    end
    do begin
      @(negedge clk_i);
      len++;
      if (mclk_en_o) begin
        gap = len - last;
        if (gap < gmin) gmin = gap;
        if (gap > gmax) gmax = gap;
        last = len;
        pulses++;
      end
      if (fs_en_o && !mclk_en_o) misal++;
    end while (!fs_en_o && len < 3000);
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (mclk_en_o || fs_en_o || mclk_valid_o) n++;
    end
  endtask

  task automatic start_cfg(input bit base, input int code);
    @(negedge clk_i); run_i = 1'b0;
    repeat (2) @(negedge clk_i);
    base_sel_i = base; mult_code_i = 3'(code); run_i = 1'b1;
    @(negedge clk_i);
    chk(mclk_valid_o == 1'b0, "R7 valid after one edge", int'(mclk_valid_o), 0);
    @(negedge clk_i);
    chk(mclk_valid_o == 1'b1, "R7 valid after two edges", int'(mclk_valid_o), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk({mclk_en_o, fs_en_o, mclk_valid_o, code_err_o} == 4'b0, "R1 in reset",
        int'({mclk_en_o, fs_en_o, mclk_valid_o, code_err_o}), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk({mclk_en_o, fs_en_o, mclk_valid_o, code_err_o} == 4'b0, "R1 after reset",
        int'({mclk_en_o, fs_en_o, mclk_valid_o, code_err_o}), 0);
  endtask

  task automatic t_family(input bit base);
    int frame, top, p, l, gmin, gmax, mis, ratio;
    frame = base ? 384 : 512;
    top   = base ? 3 : 4;
    for (int c = 0; c <= top; c++) begin
      ratio = (base ? 48 : 32) << c;
      start_cfg(base, c);
      measure(1'b1, p, l, gmin, gmax, mis);
      if (base) chk(p == ratio, "R3 pulses per frame", p, ratio);
      else      chk(p == ratio, "R2 pulses per frame", p, ratio);
      chk(l == frame, base ? "R3 frame length" : "R2 frame length", l, frame);
      chk(gmin == frame / ratio && gmax == frame / ratio, "R4 spacing", gmax, frame / ratio);
      chk(mis == 0, "R9 frame without mclk pulse", mis, 0);
    end
  endtask

  task automatic t_change();
    int p, l, gmin, gmax, mis;
    start_cfg(1'b0, 2);
    measure(1'b1, p, l, gmin, gmax, mis);
    mult_code_i = 3'd4;
    measure(1'b0, p, l, gmin, gmax, mis);
    chk(p == 128, "R8 current frame keeps old ratio", p, 128);
    chk(gmin == 4 && gmax == 4, "R8 old spacing kept", gmin, 4);
    measure(1'b0, p, l, gmin, gmax, mis);
    chk(p == 512, "R8 next frame uses new ratio", p, 512);
    chk(gmin == 1 && gmax == 1, "R8 new spacing", gmax, 1);
    base_sel_i = 1'b1; mult_code_i = 3'd1;
    measure(1'b0, p, l, gmin, gmax, mis);
    chk(p == 512 && l == 512, "R8 family change waits for frame end", p, 512);
    measure(1'b0, p, l, gmin, gmax, mis);
    chk(p == 96 && l == 384, "R8 new family applied", p, 96);
    chk(mis == 0, "R9 after family change", mis, 0);
  endtask

  task automatic t_gate();
    int n, p, l, gmin, gmax, mis;
    start_cfg(1'b0, 3);
    repeat (37) @(negedge clk_i);
    gate_i = 1'b1;
    @(negedge clk_i);
    chk(!mclk_valid_o && !mclk_en_o, "R6 gate stops output", int'(mclk_valid_o), 0);
    count_pulses(60, n);
    chk(n == 0, "R6 quiet while gated", n, 0);
    gate_i = 1'b0;
    measure(1'b1, p, l, gmin, gmax, mis);
    chk(p == 256, "R6 resumes after gate clears", p, 256);
    repeat (11) @(negedge clk_i);
    run_i = 1'b0;
    @(negedge clk_i);
    chk(!mclk_valid_o && !mclk_en_o, "R6 run clear stops output", int'(mclk_valid_o), 0);
    count_pulses(60, n);
    chk(n == 0, "R6 quiet while stopped", n, 0);
  endtask

  task automatic t_err();
    int n, p, l, gmin, gmax, mis;
    start_cfg(1'b1, 3);
    repeat (20) @(negedge clk_i);
    mult_code_i = 3'd4;
    @(negedge clk_i);
    chk(code_err_o == 1'b1, "R5 code 4 illegal in 384 family", int'(code_err_o), 1);
    chk(!mclk_valid_o, "R5 output held", int'(mclk_valid_o), 0);
    count_pulses(50, n);
    chk(n == 0, "R5 quiet on error", n, 0);
    base_sel_i = 1'b0;
    @(negedge clk_i);
    chk(code_err_o == 1'b0, "R5 code 4 legal in 512 family", int'(code_err_o), 0);
    measure(1'b1, p, l, gmin, gmax, mis);
    chk(p == 512, "R2 code 4 after error clears", p, 512);
    mult_code_i = 3'd7;
    @(negedge clk_i);
    chk(code_err_o == 1'b1 && !mclk_en_o, "R5 code 7 illegal in 512 family", int'(code_err_o), 1);
    run_i = 1'b0; mult_code_i = 3'd5;
    @(negedge clk_i);
    chk(code_err_o == 1'b1, "R5 flag independent of run", int'(code_err_o), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_family(1'b0);
        t_family(1'b1);
        t_change();
        t_gate();
        t_err();
      end
      begin
        repeat (200000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule